// File: doc/BRIEF.md
# Gated Multi-Phase Counting Time-to-Digital Back-End

This block is the digital back-end of a time-to-digital converter built around a gated ring oscillator. The width of a pulse on `measEn` is measured. While the pulse is high, the block counts the rising edges seen on seven oscillator taps. The taps come from alternate stages of an odd-length ring, so each one is shifted in phase from its neighbours. Each tap has its own saturating counter.

When the pulse falls, a programmable compensation delay lets the last in-flight count settle. The seven counts are then copied into capture registers and the counters are cleared. A fixed three-level adder tree reduces the captured counts to one result. The result is published with a single-cycle valid pulse. The oscillator and its gating are not part of the block: the taps arrive as plain inputs.

All inputs are registered once on `clk`, a fast capture clock. Counting, edge detection and the capture delay are counted in cycles of that clock.

Top module: `gro_tdc_backend`

## Requirements
- R1: While reset is asserted, and after it is released, `sumValid` is 0 and `sumOut` is 0.
- R2: Tap i gains one count at a clock edge when three conditions hold: tapIn[i] was sampled 1 at the previous edge, tapIn[i] was sampled 0 at the edge before that, and measEn was sampled 1 at the same edge as the 1.
- R3: Tap transitions sampled while measEn is sampled 0 add nothing to any count.
- R4: Each per-tap count saturates at 2^CNT_W-1 (63 by default) and does not wrap.
- R5: `sumOut` (CNT_W+3 bits, 9 by default) equals the sum of the seven counts captured for the measurement. Level one adds taps 0+1, 2+3 and 4+5 and passes tap 6 on. Level two adds the first two level-one sums, and separately the third level-one sum plus tap 6. Level three adds the two level-two sums.
- R6: Let edge F be the first clock edge at which measEn is sampled 0 after being 1. `sumValid` goes high at edge F+CAP_DELAY+3 and stays high for exactly one cycle. CAP_DELAY defaults to 4.
- R7: Counters are cleared one cycle after capture, so each measurement starts from zero regardless of the previous one.
- R8: `sumOut` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast capture clock |
| rstN | input | 1 | Asynchronous active-low reset |
| measEn | input | 1 | Pulse whose width is measured |
| tapIn | input | 7 | Oscillator tap signals, one per counter |
| sumOut | output | CNT_W+3 | Sum of the captured counts |
| sumValid | output | 1 | One-cycle pulse when `sumOut` is updated |

## Verification
The result is due CAP_DELAY+3 edges after the first edge that samples the pulse low. Counting that from the falling-edge drive, this is CAP_DELAY+4 negative edges later.

The driver records the posedge count at the moment it drops `measEn`, adds that latency, and pushes the due cycle into the queue together with the expected sum. The expected sum comes from a step-by-step model of the counting rule.

The monitor samples on the negative edge. It compares both the value and the arrival cycle of every valid pulse. On the following edge it checks that the pulse has dropped.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int TDC_TAPS = 7;

  typedef struct packed {
    logic countEn;
    logic capture;
    logic clear;
    logic publish;
  } tdcStrobe_t;
endpackage

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
#(
  parameter int CAP_DELAY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       measEn,
  output tdcStrobe_t strobe
);
  localparam int DW = $clog2(CAP_DELAY + 1);
  localparam logic [DW-1:0] DLY_LOAD = DW'(CAP_DELAY - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CAP, S_CLR} ctrlState_t;

  ctrlState_t state;
  logic enQ, enD;
  logic [DW-1:0] delayCnt;
  logic enFall;

  assign enFall = enD & ~enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0;
      enD <= 1'b0;
    end else begin
      enQ <= measEn;
      enD <= enQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      delayCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (enFall) begin
          state    <= S_WAIT;
          delayCnt <= DLY_LOAD;
        end
        S_WAIT: begin
          if (delayCnt == '0) state <= S_CAP;
          else delayCnt <= delayCnt - 1'b1;
        end
        S_CAP:   state <= S_CLR;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.countEn = (state == S_IDLE) && enQ;
    strobe.capture = (state == S_CAP);
    strobe.clear   = (state == S_CLR);
    strobe.publish = (state == S_CLR);
  end

  // R7: clearing always follows a capture by one cycle
  a_r7_clear_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> strobe.clear);

  // R6: capture and clear are single-cycle strobes
  a_r6_capture_single: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture);

  // R3: no counting is enabled while a result is being formed
  a_r3_no_count_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture || strobe.clear) |-> !strobe.countEn);
endmodule

// File: rtl/tdc_adder_tree.sv
module tdc_adder_tree
  import tdc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [TDC_TAPS-1:0][CNT_W-1:0] capIn,
  output logic [CNT_W+2:0]               sumOut
);
  localparam int L1W = CNT_W + 1;
  localparam int L2W = CNT_W + 2;
  localparam int L3W = CNT_W + 3;

  logic [2:0][L1W-1:0] lvl1;
  logic [L1W-1:0]      spare;
  logic [1:0][L2W-1:0] lvl2;

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : gLvl1
      assign lvl1[g] = {1'b0, capIn[2*g]} + {1'b0, capIn[2*g+1]};
    end
  endgenerate

  assign spare   = {1'b0, capIn[TDC_TAPS-1]};
  assign lvl2[0] = {1'b0, lvl1[0]} + {1'b0, lvl1[1]};
  assign lvl2[1] = {1'b0, lvl1[2]} + {1'b0, spare};
  assign sumOut  = L3W'({1'b0, lvl2[0]} + {1'b0, lvl2[1]});
endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TDC_TAPS-1:0] tapIn,
  input  tdcStrobe_t          strobe,
  output logic [CNT_W+2:0]    sumOut,
  output logic                sumValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TDC_TAPS-1:0] tapQ, tapPrev, tapRise;
  logic [TDC_TAPS-1:0][CNT_W-1:0] cnt;
  logic [TDC_TAPS-1:0][CNT_W-1:0] capReg;
  logic [CNT_W+2:0] treeSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapQ    <= '0;
      tapPrev <= '0;
    end else begin
      tapQ    <= tapIn;
      tapPrev <= tapQ;
    end
  end

  assign tapRise = tapQ & ~tapPrev;

  genvar t;
  generate
    for (t = 0; t < TDC_TAPS; t++) begin : gTap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cnt[t] <= '0;
        else if (strobe.clear)
          cnt[t] <= '0;
        else if (strobe.countEn && tapRise[t] && (cnt[t] != CNT_MAX))
          cnt[t] <= cnt[t] + 1'b1;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) capReg[t] <= '0;
        else if (strobe.capture) capReg[t] <= cnt[t];
      end

      // R4: a saturated counter stays put until cleared
      a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
        (cnt[t] == CNT_MAX && !strobe.clear) |=> cnt[t] == CNT_MAX);

      // R3: counts do not move while counting is disabled
      a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.countEn && !strobe.clear) |=> $stable(cnt[t]));

      // R7: a clear leaves the counter at zero
      a_r7_cleared: assert property (@(posedge clk) disable iff (!rstN)
        strobe.clear |=> cnt[t] == '0);
    end
  endgenerate

  tdc_adder_tree #(.CNT_W(CNT_W)) u_tree (
    .capIn  (capReg),
    .sumOut (treeSum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumOut   <= '0;
      sumValid <= 1'b0;
    end else begin
      sumValid <= strobe.publish;
      if (strobe.publish) sumOut <= treeSum;
    end
  end

  // R6: the valid flag lasts a single cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |=> !sumValid);

  // R8: the result only changes together with a valid pulse
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> $stable(sumOut));
endmodule

// File: rtl/gro_tdc_backend.sv
module gro_tdc_backend
  import tdc_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int CAP_DELAY = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                measEn,
  input  logic [TDC_TAPS-1:0] tapIn,
  output logic [CNT_W+2:0]    sumOut,
  output logic                sumValid
);
  tdcStrobe_t strobe;

  tdc_ctrl #(.CAP_DELAY(CAP_DELAY)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .measEn (measEn),
    .strobe (strobe)
  );

  tdc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tapIn    (tapIn),
    .strobe   (strobe),
    .sumOut   (sumOut),
    .sumValid (sumValid)
  );
endmodule

// File: tb/gro_tdc_backend_tb.sv
module gro_tdc_backend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int CAP_DELAY  = 4;
  localparam int TAPS       = 7;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic measEn = 1'b0;
  logic [TAPS-1:0] tapIn = '0;
  logic [CNT_W+2:0] sumOut;
  logic sumValid;

  gro_tdc_backend #(.CNT_W(CNT_W), .CAP_DELAY(CAP_DELAY)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .measEn   (measEn),
    .tapIn    (tapIn),
    .sumOut   (sumOut),
    .sumValid (sumValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int sum;
    int due;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int nTests = 0, nFail = 0, cyc = 0, stepCnt = 0;
  int nPush = 0, nPop = 0, lastSum = 0;
  bit done = 0;
  logic [TAPS-1:0] prevTap = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic tapVal(int t, int hp, int ph);
    return logic'(((t + ph) / hp) % 2);
  endfunction

  // drive one negedge step and update the count model
  task automatic driveStep(input bit en, input int hp, input int phStep, inout int cnt[TAPS]);
    logic [TAPS-1:0] nv;
    @(negedge clk);
    for (int i = 0; i < TAPS; i++) nv[i] = tapVal(stepCnt, hp, i * phStep);
    measEn = en;
    tapIn = nv;
    if (en)
      for (int i = 0; i < TAPS; i++)
        if (nv[i] && !prevTap[i] && cnt[i] < CMAX) cnt[i]++;
    prevTap = nv;
    stepCnt++;
  endtask

  task automatic measure(input int onCyc, input int hp, input int phStep,
                         input bit gapToggle, input string tag);
    int cnt[TAPS];
    int s;
    expItem_t it;
    for (int i = 0; i < TAPS; i++) cnt[i] = 0;
    // R8: result held from the previous measurement
    if (nPop > 0) check(sumOut == lastSum, "R8 hold", int'(sumOut), lastSum);
    for (int k = 0; k < onCyc; k++) driveStep(1'b1, hp, phStep, cnt);
    s = 0;
    for (int i = 0; i < TAPS; i++) s += cnt[i];
    @(negedge clk);
    measEn = 1'b0;
    it.sum = s;
    it.due = cyc + CAP_DELAY + 4;
    it.tag = tag;
    expQ.push_back(it);
    nPush++;
    // gap: taps keep moving while measEn is low (R3)
    for (int k = 0; k < CAP_DELAY + 12; k++)
      driveStep(1'b0, gapToggle ? 1 : 1000000, phStep, cnt);
  endtask

  // monitor
  initial begin
    bit prevValid = 0;
    expItem_t it;
    forever begin
      @(negedge clk);
      if (prevValid) check(!sumValid, "R6 single-cycle valid", int'(sumValid), 0);
      prevValid = sumValid;
      if (sumValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected result", int'(sumOut), -1);
        end else begin
          it = expQ.pop_front();
          nPop++;
          check(sumOut == it.sum, it.tag, int'(sumOut), it.sum);
          check(cyc == it.due, "R6 latency", cyc, it.due);
          lastSum = int'(sumOut);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sumValid == 1'b0, "R1 valid in reset", int'(sumValid), 0);
    check(sumOut == '0, "R1 sum in reset", int'(sumOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sumValid == 1'b0 && sumOut == '0, "R1 after reset", int'(sumOut), 0);

    measure(20, 2, 1, 1'b1, "R2 R5 hp2 pulse");
    measure(17, 1, 0, 1'b1, "R2 R5 every-cycle taps");
    measure(30, 3, 2, 1'b1, "R5 R7 wider phases");
    measure(1, 1000000, 0, 1'b0, "R5 R7 one-cycle flat pulse");
    measure(200, 1, 1, 1'b1, "R4 saturation");
    measure(5, 1000000, 0, 1'b1, "R3 gap toggles ignored");
    for (int r = 0; r < 12; r++)
      measure(1 + $urandom % 90, 1 + $urandom % 3, $urandom % 3, 1'b1, "R2 R5 random");

    repeat (30) @(negedge clk);
    check(nPush == nPop, "R6 results delivered", nPop, nPush);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule